// File: doc/BRIEF.md
# BCD Time-of-Day Register File

This block keeps calendar time as packed BCD: seconds, minutes, hours, weekday, day of month, month and a two-digit year. It counts on a one-second tick and exposes the fields through a byte-wide register window. A host writes fields one at a time. Each write is checked for range, and a field that fails is left unchanged. Reads return BCD.

The top bit of the seconds register is a stop bit. While it is set the time holds still, and clearing it resumes counting from the held value. The weekday register also stores a century flag, and a control byte has fixed bits forced on every write. All the time fields are also driven straight out, so other blocks can use them without going through the bus.

The parameter `BASE_YEAR` gives the full calendar year that stored year 00 stands for (default 1968). Only leap-year month lengths depend on it.

Top module: `bcd_tod_regs`

## Requirements
- R1: After reset the time is 00:00:00, weekday 1, date 01, month 01, year 00. The century flag, the stop bit and the control byte are all zero.
- R2: Each cycle with `tick_1hz` high advances the time by one second, provided the clock is not stopped and no time-register write is present. Seconds roll 59 to 00 into minutes, minutes roll 59 to 00 into hours, and hours roll 23 to 00 into the day. A day step moves the weekday 1 through 7 and then back to 1; a weekday of 0 steps to 1.
- R3: On a day step, a date at or past the month length goes to 01 and the month advances. Months 04, 06, 09 and 11 have 30 days. February has 29 days when `BASE_YEAR` plus the binary year is a Gregorian leap year, and 28 otherwise. All other months have 31 days.
- R4: Register addresses are: 0 control, 1 seconds, 2 minutes, 3 hours, 4 weekday, 5 date, 6 month, 7 year, 8 spare. A seconds or minutes write takes bits 6:0 and a hours write takes bits 5:0. Each is accepted only as valid BCD in 00..59 for seconds and minutes, or 00..23 for hours.
- R5: A date write takes bits 5:0 and is accepted only as valid BCD in 01..31. A month write takes bits 4:0 and is accepted only in 01..12. A year write takes all 8 bits and is accepted only as valid BCD in 00..99. A rejected write leaves the field unchanged.
- R6: Every seconds write copies bit 7 into the stop bit, whether or not the seconds value is accepted. While the stop bit is set, ticks are ignored. After it clears, counting continues from the held time.
- R7: A weekday write stores bits 2:0 as the weekday and bit 6 as the century flag. A read returns the century flag in bit 6 and the weekday in bits 2:0, with all other bits zero.
- R8: A control write stores `(wdata & 0x5F) | 0x90`, and a read returns that stored value.
- R9: Reads are combinational on `reg_addr`. The seconds register reads as the stop bit in bit 7 above the BCD seconds. The minutes, hours, date, month and year registers read as BCD. The spare register at address 8 always reads 0x00, and addresses 9..15 read 0xFF.
- R10: A write to any of addresses 1..7 in a cycle where `tick_1hz` is high takes effect at the next clock edge, and that tick is discarded.
- R11: A day step from 31 December moves the month to 01. The year steps from 99 to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| reg_addr | input | AW (4) | Register address |
| reg_we | input | 1 | Write enable |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| tod_sec | output | 8 | BCD seconds |
| tod_min | output | 8 | BCD minutes |
| tod_hour | output | 8 | BCD hours |
| tod_wday | output | 3 | Weekday |
| tod_date | output | 8 | BCD day of month |
| tod_month | output | 8 | BCD month |
| tod_year | output | 8 | BCD two-digit year |
| tod_stopped | output | 1 | Stop bit |

## Verification
The following are checked on every cycle:
- seconds, minutes and hours always hold legal BCD values;
- month and date stay in range;
- the spare address reads zero;
- a stopped clock holds its seconds;
- a tick that does count changes the seconds;
- a tick that collides with a write does not change the seconds.

The remaining behaviour can only be shown by the bench's scenarios:
- exact acceptance or rejection of every write code for each field;
- the carry chain over two hours of ticks;
- month-end and leap-February rollover;
- the year wrap;
- weekday wrap and the century flag;
- the forced control bits;
- resuming after a stop;
- the read-back format.

// File: rtl/bcd_tod_regs.sv
module bcd_tod_regs #(
  parameter int BASE_YEAR = 1968,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_1hz,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_we,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic [7:0]    tod_sec,
  output logic [7:0]    tod_min,
  output logic [7:0]    tod_hour,
  output logic [2:0]    tod_wday,
  output logic [7:0]    tod_date,
  output logic [7:0]    tod_month,
  output logic [7:0]    tod_year,
  output logic          tod_stopped
);
  localparam logic [AW-1:0] A_CTRL  = AW'(0);
  localparam logic [AW-1:0] A_SEC   = AW'(1);
  localparam logic [AW-1:0] A_MIN   = AW'(2);
  localparam logic [AW-1:0] A_HOUR  = AW'(3);
  localparam logic [AW-1:0] A_WDAY  = AW'(4);
  localparam logic [AW-1:0] A_DATE  = AW'(5);
  localparam logic [AW-1:0] A_MONTH = AW'(6);
  localparam logic [AW-1:0] A_YEAR  = AW'(7);
  localparam logic [AW-1:0] A_SPARE = AW'(8);

  logic [7:0] sec, min, hour, date, month, year, ctrl, mlen;
  logic [2:0] wday;
  logic       century, stop;
  logic       time_wr, adv, c_sec, c_min, c_hour, c_date, c_mon;

  function automatic logic bcd_ok(input logic [7:0] v, input logic [7:0] lo, input logic [7:0] hi);
    return (v[3:0] <= 4'd9) && (v >= lo) && (v <= hi);
  endfunction

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'h0} : v + 8'd1;
  endfunction

  function automatic logic is_leap(input logic [7:0] y);
    int f;
    f = BASE_YEAR + int'(y[7:4]) * 10 + int'(y[3:0]);
    return (f % 4 == 0) && ((f % 100 != 0) || (f % 400 == 0));
  endfunction

  always_comb begin
    case (month)
      8'h02:                      mlen = is_leap(year) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: mlen = 8'h30;
      default:                    mlen = 8'h31;
    endcase
  end

  assign time_wr = reg_we && (reg_addr >= A_SEC) && (reg_addr <= A_YEAR);
  assign adv     = tick_1hz && !stop && !time_wr;
  assign c_sec   = sec == 8'h59;
  assign c_min   = c_sec && (min == 8'h59);
  assign c_hour  = c_min && (hour == 8'h23);
  assign c_date  = c_hour && (date >= mlen);
  assign c_mon   = c_date && (month == 8'h12);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec     <= 8'h00;
      min     <= 8'h00;
      hour    <= 8'h00;
      wday    <= 3'd1;
      date    <= 8'h01;
      month   <= 8'h01;
      year    <= 8'h00;
      century <= 1'b0;
      stop    <= 1'b0;
      ctrl    <= 8'h00;
    end else begin
      if (adv) begin
        sec <= c_sec ? 8'h00 : bcd_inc(sec);
        if (c_sec) min <= (min == 8'h59) ? 8'h00 : bcd_inc(min);
        if (c_min) hour <= (hour == 8'h23) ? 8'h00 : bcd_inc(hour);
        if (c_hour) begin
          wday <= (wday == 3'd7) ? 3'd1 : wday + 3'd1;
          date <= c_date ? 8'h01 : bcd_inc(date);
        end
        if (c_date) month <= c_mon ? 8'h01 : bcd_inc(month);
        if (c_mon) year <= (year == 8'h99) ? 8'h00 : bcd_inc(year);
      end
      if (reg_we) begin
        case (reg_addr)
          A_CTRL: ctrl <= (reg_wdata & 8'h5F) | 8'h90;
          A_SEC: begin
            stop <= reg_wdata[7];
            if (bcd_ok({1'b0, reg_wdata[6:0]}, 8'h00, 8'h59)) sec <= {1'b0, reg_wdata[6:0]};
          end
          A_MIN:
            if (bcd_ok({1'b0, reg_wdata[6:0]}, 8'h00, 8'h59)) min <= {1'b0, reg_wdata[6:0]};
          A_HOUR:
            if (bcd_ok({2'b0, reg_wdata[5:0]}, 8'h00, 8'h23)) hour <= {2'b0, reg_wdata[5:0]};
          A_WDAY: begin
            wday    <= reg_wdata[2:0];
            century <= reg_wdata[6];
          end
          A_DATE:
            if (bcd_ok({2'b0, reg_wdata[5:0]}, 8'h01, 8'h31)) date <= {2'b0, reg_wdata[5:0]};
          A_MONTH:
            if (bcd_ok({3'b0, reg_wdata[4:0]}, 8'h01, 8'h12)) month <= {3'b0, reg_wdata[4:0]};
          A_YEAR:
            if (bcd_ok(reg_wdata, 8'h00, 8'h99)) year <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = ctrl;
      A_SEC:   reg_rdata = {stop, sec[6:0]};
      A_MIN:   reg_rdata = min;
      A_HOUR:  reg_rdata = hour;
      A_WDAY:  reg_rdata = {1'b0, century, 3'b000, wday};
      A_DATE:  reg_rdata = date;
      A_MONTH: reg_rdata = month;
      A_YEAR:  reg_rdata = year;
      A_SPARE: reg_rdata = 8'h00;
      default: reg_rdata = 8'hFF;
    endcase
  end

  assign tod_sec     = sec;
  assign tod_min     = min;
  assign tod_hour    = hour;
  assign tod_wday    = wday;
  assign tod_date    = date;
  assign tod_month   = month;
  assign tod_year    = year;
  assign tod_stopped = stop;
endmodule

// File: rtl/bcd_tod_regs_chk.sv
module bcd_tod_regs_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_1hz,
  input logic [AW-1:0] reg_addr,
  input logic          reg_we,
  input logic [7:0]    reg_rdata,
  input logic [7:0]    tod_sec,
  input logic [7:0]    tod_min,
  input logic [7:0]    tod_hour,
  input logic [7:0]    tod_date,
  input logic [7:0]    tod_month,
  input logic          tod_stopped
);
  logic any_time_wr, sec_wr, other_time_wr;
  assign any_time_wr   = reg_we && (int'(reg_addr) >= 1) && (int'(reg_addr) <= 7);
  assign sec_wr        = reg_we && (int'(reg_addr) == 1);
  assign other_time_wr = reg_we && (int'(reg_addr) >= 2) && (int'(reg_addr) <= 7);

  // R2
  tick_advances_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1hz && !tod_stopped && !any_time_wr) |=> (tod_sec != $past(tod_sec)));

  // R6
  stop_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tod_stopped && !sec_wr) |=> $stable(tod_sec));

  // R10
  tick_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1hz && other_time_wr) |=> $stable(tod_sec));

  // R4
  clock_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tod_sec[3:0] <= 4'd9) && (tod_sec <= 8'h59) && (tod_min[3:0] <= 4'd9) &&
    (tod_min <= 8'h59) && (tod_hour[3:0] <= 4'd9) && (tod_hour <= 8'h23));

  // R5
  cal_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tod_month >= 8'h01) && (tod_month <= 8'h12) && (tod_date >= 8'h01) && (tod_date <= 8'h31));

  // R9
  spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(reg_addr) == 8) |-> (reg_rdata == 8'h00));
endmodule

bind bcd_tod_regs bcd_tod_regs_chk #(.AW(AW)) i_chk (
  .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_rdata(reg_rdata), .tod_sec(tod_sec), .tod_min(tod_min), .tod_hour(tod_hour),
  .tod_date(tod_date), .tod_month(tod_month), .tod_stopped(tod_stopped));

// File: tb/test_bcd_tod_regs.sv
`timescale 1ns/1ps
module test_bcd_tod_regs;
  localparam int BASE = 1968;
  logic clk = 1'b0, rst_n = 1'b0, tick_1hz = 1'b0, reg_we = 1'b0;
  logic [3:0] reg_addr = 4'd0;
  logic [7:0] reg_wdata = 8'h00, reg_rdata;
  logic [7:0] tod_sec, tod_min, tod_hour, tod_date, tod_month, tod_year;
  logic [2:0] tod_wday;
  logic tod_stopped;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bcd_tod_regs #(.BASE_YEAR(BASE)) i_bcd_tod_regs (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tod_sec(tod_sec), .tod_min(tod_min),
    .tod_hour(tod_hour), .tod_wday(tod_wday), .tod_date(tod_date), .tod_month(tod_month),
    .tod_year(tod_year), .tod_stopped(tod_stopped));

  function automatic int tobcd(input int n);
    return (n / 10) * 16 + (n % 10);
  endfunction

  function automatic int mdays(input int m, input int y);
    int f;
    f = BASE + y;
    if (m == 2) return ((f % 4 == 0) && ((f % 100 != 0) || (f % 400 == 0))) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_addr = 4'(a); reg_wdata = 8'(d); reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    reg_addr = 4'(a);
    #1 d = int'(reg_rdata);
  endtask

  task automatic tick1();
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
  endtask

  task automatic set_all(input int h, input int m, input int s, input int dt, input int mo, input int y);
    wr(7, y); wr(6, mo); wr(5, dt); wr(3, h); wr(2, m); wr(1, s);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int d, exp, t, o, mv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(0, d); check("R1 ctrl", d, 8'h00);
    rd(1, d); check("R1 sec", d, 8'h00);
    rd(2, d); check("R1 min", d, 8'h00);
    rd(3, d); check("R1 hour", d, 8'h00);
    rd(4, d); check("R1 wday", d, 8'h01);
    rd(5, d); check("R1 date", d, 8'h01);
    rd(6, d); check("R1 month", d, 8'h01);
    rd(7, d); check("R1 year", d, 8'h00);
    check("R1 stopped", int'(tod_stopped), 0);

    // R4 seconds / minutes / hours sweeps
    exp = 0;
    for (int v = 0; v < 128; v++) begin
      wr(1, v); t = v >> 4; o = v & 15;
      if (t <= 5 && o <= 9) exp = v;
      rd(1, d); check("R4 sec write", d, exp);
    end
    exp = 8'h59;
    for (int v = 0; v < 256; v++) begin
      mv = v & 8'h7F; wr(2, v); t = mv >> 4; o = mv & 15;
      if (t <= 5 && o <= 9) exp = mv;
      rd(2, d); check("R4 min write", d, exp);
    end
    exp = 0;
    for (int v = 0; v < 256; v++) begin
      mv = v & 8'h3F; wr(3, v); t = mv >> 4; o = mv & 15;
      if (o <= 9 && t * 10 + o <= 23) exp = mv;
      rd(3, d); check("R4 hour write", d, exp);
    end
    // R5 date / month / year sweeps
    exp = 1;
    for (int v = 0; v < 256; v++) begin
      mv = v & 8'h3F; wr(5, v); t = mv >> 4; o = mv & 15;
      if (o <= 9 && t * 10 + o >= 1 && t * 10 + o <= 31) exp = mv;
      rd(5, d); check("R5 date write", d, exp);
    end
    exp = 1;
    for (int v = 0; v < 256; v++) begin
      mv = v & 8'h1F; wr(6, v); t = mv >> 4; o = mv & 15;
      if (o <= 9 && t * 10 + o >= 1 && t * 10 + o <= 12) exp = mv;
      rd(6, d); check("R5 month write", d, exp);
    end
    exp = 0;
    for (int v = 0; v < 256; v++) begin
      wr(7, v); t = v >> 4; o = v & 15;
      if (t <= 9 && o <= 9) exp = v;
      rd(7, d); check("R5 year write", d, exp);
    end

    // R2 continuous counting over two hours
    set_all(0, 0, 0, 1, 1, 0);
    @(negedge clk); tick_1hz = 1'b1;
    for (int i = 1; i <= 7300; i++) begin
      @(negedge clk);
      check("R2 sec", int'(tod_sec), tobcd(i % 60));
      check("R2 min", int'(tod_min), tobcd((i / 60) % 60));
      check("R2 hour", int'(tod_hour), tobcd(i / 3600));
    end
    tick_1hz = 1'b0;

    // R3 / R11 month ends over several years
    for (int yi = 0; yi < 5; yi++) begin
      int y;
      y = (yi == 0) ? 0 : (yi == 1) ? 1 : (yi == 2) ? 31 : (yi == 3) ? 32 : 99;
      for (int m = 1; m <= 12; m++) begin
        set_all(8'h23, 8'h59, 8'h59, tobcd(mdays(m, y) - 1), tobcd(m), tobcd(y));
        tick1();
        check("R3 day before end", int'(tod_date), tobcd(mdays(m, y)));
        check("R3 month kept", int'(tod_month), tobcd(m));
        wr(3, 8'h23); wr(2, 8'h59); wr(1, 8'h59);
        tick1();
        check("R3 date wrap", int'(tod_date), 8'h01);
        check("R3 month step", int'(tod_month), tobcd(m == 12 ? 1 : m + 1));
        check("R11 year", int'(tod_year), tobcd(m == 12 ? (y + 1) % 100 : y));
        check("R2 midnight", int'({tod_hour, tod_min, tod_sec}), 0);
      end
    end

    // R7 weekday and century
    wr(4, 8'h47); rd(4, d); check("R7 wday read", d, 8'h47);
    set_all(8'h23, 8'h59, 8'h59, 8'h10, 8'h05, 8'h20);
    tick1(); rd(4, d); check("R7 R2 wday wrap", d, 8'h41);
    wr(4, 8'hBB); rd(4, d); check("R7 wday mask", d, 8'h03);
    set_all(8'h23, 8'h59, 8'h59, 8'h10, 8'h05, 8'h20);
    tick1(); check("R2 wday step", int'(tod_wday), 4);

    // R6 stop and resume
    wr(1, 8'hB0); rd(1, d); check("R6 stop read", d, 8'hB0);
    repeat (5) tick1();
    rd(1, d); check("R6 frozen", d, 8'hB0);
    wr(1, 8'h7F); rd(1, d); check("R6 resume keeps sec", d, 8'h30);
    tick1(); rd(1, d); check("R6 counts again", d, 8'h31);

    // R10 write and tick in the same cycle
    wr(1, 8'h10);
    @(negedge clk); tick_1hz = 1'b1; reg_addr = 4'd2; reg_wdata = 8'h45; reg_we = 1'b1;
    @(negedge clk); tick_1hz = 1'b0; reg_we = 1'b0;
    check("R10 tick dropped", int'(tod_sec), 8'h10);
    check("R10 write applied", int'(tod_min), 8'h45);
    tick1(); check("R10 next tick", int'(tod_sec), 8'h11);

    // R8 control
    wr(0, 8'hFF); rd(0, d); check("R8 ctrl FF", d, 8'hDF);
    wr(0, 8'h00); rd(0, d); check("R8 ctrl 00", d, 8'h90);
    wr(0, 8'h2A); rd(0, d); check("R8 ctrl 2A", d, 8'h9A);

    // R9 spare and unmapped
    wr(8, 8'h55); rd(8, d); check("R9 spare", d, 8'h00);
    for (int a = 9; a < 16; a++) begin
      rd(a, d); check("R9 unmapped", d, 8'hFF);
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule